// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Step

This unit advances a SHA-1 working state by four compression rounds each time it is started. The caller supplies the four-word state vector (words A..D packed into 128 bits, word 0 in the low 32 bits), a separate fifth word E, and a 128-bit vector holding four message words with the round constant already added. A 2-bit selector picks which boolean round function all four rounds use: choose, parity or majority.

After a start pulse is accepted, the unit runs one round per clock, using word i of the added-message vector in round i. Each round mixes words 1..3 through the selected function, adds word 0 rotated left by five, the function value, E and the message word into a new word, rotates word 1 left by thirty, and then shifts the five-word state one position: the new word lands in position 0, the others move up one place, and the old word 3 becomes the next E. Only the resulting 128-bit vector is presented; the final E is dropped. A one-cycle done pulse marks the result as valid, and the result stays on the output until the next accepted start.

Top module: `sha1q_quad_round`

## Requirements
- R1: After reset, `done_o` is 0 and `abcd_o` is all zeros.
- R2: A start sampled while the unit is idle is accepted; `done_o` is high for exactly one cycle, in the cycle following the fourth clock edge after the edge that sampled the start.
- R3: With `fsel_i` = 0 every round uses the choose function ((y XOR z) AND x) XOR z, where x, y, z are state words 1, 2, 3.
- R4: With `fsel_i` = 1 every round uses the parity function x XOR y XOR z.
- R5: With `fsel_i` = 2 every round uses the majority function (x AND y) OR ((x OR y) AND z).
- R6: With `fsel_i` = 3 the result equals that obtained with `fsel_i` = 1 (parity).
- R7: Round i (i = 0..3) adds word i of `wk_i`, taken from bits [32i+31:32i]; state word k sits in bits [32k+31:32k] of both `abcd_i` and `abcd_o`.
- R8: All sums wrap modulo 2^32.
- R9: A start raised while four rounds are in progress is ignored: the running result, its done timing and the captured selector are unchanged, and no further done follows.
- R10: While the unit is idle and no start is given, `abcd_o` holds the last result regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on a rising edge |
| fsel_i | input | 2 | Round function select: 0 choose, 1 parity, 2 majority, 3 parity |
| abcd_i | input | 128 | Incoming state words A..D, word 0 in bits 31:0 |
| e_i | input | 32 | Incoming fifth state word E |
| wk_i | input | 128 | Four message-plus-constant words, word 0 in bits 31:0 |
| abcd_o | output | 128 | State words after four rounds, word 0 in bits 31:0 |
| done_o | output | 1 | One-cycle pulse: `abcd_o` holds a fresh result |

## Verification
The assertions assume the selector and data inputs matter only in the cycle where a start is accepted, and that reset is applied before the first start; the stimulus changes inputs only on falling edges and drives a fresh start only after the previous done pulse. The one deliberate departure, a start inside a running operation, is used to show that such a request is dropped rather than queued. The sweep covers every selector value with pseudo-random state, single-nonzero message vectors that expose word ordering, and all-ones operands that force carries past bit 31.

// File: rtl/sha1q_pkg.sv
package sha1q_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int ROT_A  = 5;
  localparam int ROT_B  = 30;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0][WORD_W-1:0] vec_t;

  typedef enum logic [1:0] {
    FN_CHOOSE = 2'd0,
    FN_PARITY = 2'd1,
    FN_MAJOR  = 2'd2,
    FN_SPARE  = 2'd3
  } fn_sel_e;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t fn_choose(input word_t x, input word_t y, input word_t z);
    return ((y ^ z) & x) ^ z;
  endfunction

  function automatic word_t fn_parity(input word_t x, input word_t y, input word_t z);
    return x ^ y ^ z;
  endfunction

  function automatic word_t fn_major(input word_t x, input word_t y, input word_t z);
    return (x & y) | ((x | y) & z);
  endfunction

endpackage

// File: rtl/sha1q_mix.sv
module sha1q_mix
  import sha1q_pkg::*;
(
  input  logic [1:0] fsel,
  input  word_t      x,
  input  word_t      y,
  input  word_t      z,
  output word_t      f
);

  always_comb begin
    case (fn_sel_e'(fsel))
      FN_CHOOSE: f = fn_choose(x, y, z);
      FN_MAJOR:  f = fn_major(x, y, z);
      default:   f = fn_parity(x, y, z);
    endcase
  end

endmodule

// File: rtl/sha1q_round.sv
module sha1q_round
  import sha1q_pkg::*;
(
  input  logic [1:0] fsel,
  input  vec_t       st_cur,
  input  word_t      e_cur,
  input  word_t      wk_word,
  output vec_t       st_nxt,
  output word_t      e_nxt
);

  word_t f_val;
  word_t new_word;
  word_t w1_rot;

  sha1q_mix u_mix (
    .fsel (fsel),
    .x    (st_cur[1]),
    .y    (st_cur[2]),
    .z    (st_cur[3]),
    .f    (f_val)
  );

  always_comb begin
    new_word  = e_cur + rotl(st_cur[0], ROT_A) + f_val + wk_word;
    w1_rot    = rotl(st_cur[1], ROT_B);
    st_nxt[0] = new_word;
    st_nxt[1] = st_cur[0];
    st_nxt[2] = w1_rot;
    st_nxt[3] = st_cur[2];
    e_nxt     = st_cur[3];
  end

endmodule

// File: rtl/sha1q_seq.sv
module sha1q_seq #(
  parameter int NUM_ROUNDS = 4,
  localparam int IDX_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             step,
  output logic [IDX_W-1:0] round_idx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

  logic last_round;

  assign load       = start && !busy;
  assign step       = busy;
  assign last_round = busy && (round_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      round_idx <= '0;
      done      <= 1'b0;
    end else begin
      done <= last_round;
      if (load) begin
        busy      <= 1'b1;
        round_idx <= '0;
      end else if (busy) begin
        if (last_round) begin
          busy      <= 1'b0;
          round_idx <= '0;
        end else begin
          round_idx <= round_idx + 1'b1;
        end
      end
    end
  end

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_run_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_round) |=> (busy && round_idx == IDX_W'($past(round_idx) + 1'b1)));

endmodule

// File: rtl/sha1q_quad_round.sv
module sha1q_quad_round
  import sha1q_pkg::*;
#(
  parameter int NUM_ROUNDS = LANES,
  localparam int IDX_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   fsel_i,
  input  logic [127:0] abcd_i,
  input  logic [31:0]  e_i,
  input  logic [127:0] wk_i,
  output logic [127:0] abcd_o,
  output logic         done_o
);

  logic             load;
  logic             step;
  logic             busy;
  logic [IDX_W-1:0] round_idx;

  vec_t       st_q;
  word_t      e_q;
  vec_t       wk_q;
  logic [1:0] fsel_q;
  vec_t       st_d;
  word_t      e_d;
  word_t      wk_cur;

  sha1q_seq #(.NUM_ROUNDS(NUM_ROUNDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .load      (load),
    .step      (step),
    .round_idx (round_idx),
    .busy      (busy),
    .done      (done_o)
  );

  assign wk_cur = wk_q[round_idx];

  sha1q_round u_round (
    .fsel    (fsel_q),
    .st_cur  (st_q),
    .e_cur   (e_q),
    .wk_word (wk_cur),
    .st_nxt  (st_d),
    .e_nxt   (e_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      e_q    <= '0;
      wk_q   <= '0;
      fsel_q <= '0;
    end else if (load) begin
      st_q   <= vec_t'(abcd_i);
      e_q    <= e_i;
      wk_q   <= vec_t'(wk_i);
      fsel_q <= fsel_i;
    end else if (step) begin
      st_q <= st_d;
      e_q  <= e_d;
    end
  end

  assign abcd_o = st_q;

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(abcd_o));

  assert_sel_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fsel_q) && $stable(wk_q)));

  assert_e_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (e_q == $past(st_q[3])));

endmodule

// File: tb/tb_sha1q_quad_round.sv
`timescale 1ns/1ps
module tb_sha1q_quad_round;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   fsel_i = 2'd0;
  logic [127:0] abcd_i = '0;
  logic [31:0]  e_i = '0;
  logic [127:0] wk_i = '0;
  logic [127:0] abcd_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  sha1q_quad_round dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .fsel_i (fsel_i),
    .abcd_i (abcd_i), .e_i (e_i), .wk_i (wk_i), .abcd_o (abcd_o), .done_o (done_o)
  );

  function automatic logic [127:0] ref_run(input logic [127:0] s, input logic [31:0] e,
                                           input logic [127:0] wk, input logic [1:0] sel);
    logic [31:0] v [5];
    logic [31:0] x, y, z, f, t, r1, old3;
    for (int k = 0; k < 4; k++) v[k] = s[32*k +: 32];
    v[4] = e;
    for (int r = 0; r < 4; r++) begin
      x = v[1]; y = v[2]; z = v[3];
      case (sel)
        2'd0:    f = (x & y) | (~x & z);
        2'd2:    f = (x & y) | (x & z) | (y & z);
        default: f = x ^ y ^ z;
      endcase
      t    = {v[0][26:0], v[0][31:27]} + f + v[4] + wk[32*r +: 32];
      r1   = {v[1][1:0], v[1][31:2]};
      old3 = v[3];
      v[3] = v[2];
      v[2] = r1;
      v[1] = v[0];
      v[0] = t;
      v[4] = old3;
    end
    return {v[3], v[2], v[1], v[0]};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] q = s;
    q ^= q << 13; q ^= q >> 17; q ^= q << 5;
    return q;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rnd128(output logic [127:0] v);
    for (int k = 0; k < 4; k++) begin
      seed = nxt(seed);
      v[32*k +: 32] = seed;
    end
  endtask

  // drive one operation and check latency, pulse and result
  task automatic run_op(input logic [127:0] s, input logic [31:0] e, input logic [127:0] wk,
                        input logic [1:0] sel, input logic [127:0] exp, input string tag);
    @(negedge clk);
    abcd_i = s; e_i = e; wk_i = wk; fsel_i = sel; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(done_o == 1'b0, "R2 early done", {127'd0, done_o}, 128'd0);
    @(negedge clk);
    chk(done_o == 1'b1, "R2 done latency", {127'd0, done_o}, 128'd1);
    chk(abcd_o == exp, tag, abcd_o, exp);
    @(negedge clk);
    chk(done_o == 1'b0, "R2 done one cycle", {127'd0, done_o}, 128'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] s, wk, exp, hold;
    logic [31:0]  e;
    string        tag;
    #1;
    chk(done_o == 1'b0 && abcd_o == '0, "R1 reset", abcd_o, 128'd0);
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0 && abcd_o == '0, "R1 after reset", abcd_o, 128'd0);

    // R3 R4 R5 R6: random sweep over every selector
    for (int sel = 0; sel < 4; sel++) begin
      for (int n = 0; n < 24; n++) begin
        rnd128(s); rnd128(wk); seed = nxt(seed); e = seed;
        exp = ref_run(s, e, wk, (sel == 3) ? 2'd1 : 2'(sel));
        case (sel)
          0: tag = "R3 choose";
          1: tag = "R4 parity";
          2: tag = "R5 majority";
          default: tag = "R6 sel3 as parity";
        endcase
        run_op(s, e, wk, 2'(sel), exp, tag);
      end
    end

    // R7: one nonzero message word at a time exposes word order
    for (int k = 0; k < 4; k++) begin
      for (int sel = 0; sel < 3; sel++) begin
        wk = '0;
        wk[32*k +: 32] = 32'h0000_0001 << (k * 3 + 1);
        s = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        exp = ref_run(s, 32'h0, wk, 2'(sel));
        run_op(s, 32'h0, wk, 2'(sel), exp, "R7 word order");
      end
    end

    // R8: all-ones operands force wraparound
    for (int sel = 0; sel < 3; sel++) begin
      s = '1; wk = '1;
      exp = ref_run(s, 32'hffff_ffff, wk, 2'(sel));
      run_op(s, 32'hffff_ffff, wk, 2'(sel), exp, "R8 modulo wrap");
    end

    // R9: start during a running operation is dropped
    rnd128(s); rnd128(wk); seed = nxt(seed); e = seed;
    exp = ref_run(s, e, wk, 2'd2);
    @(negedge clk);
    abcd_i = s; e_i = e; wk_i = wk; fsel_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    abcd_i = ~s; e_i = ~e; wk_i = ~wk; fsel_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R9 timing kept", {127'd0, done_o}, 128'd0);
    @(negedge clk);
    chk(done_o == 1'b1, "R9 done kept", {127'd0, done_o}, 128'd1);
    chk(abcd_o == exp, "R9 result kept", abcd_o, exp);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R9 no queued op", {127'd0, done_o}, 128'd0);
    end

    // R10: output holds while idle
    hold = abcd_o;
    for (int k = 0; k < 8; k++) begin
      rnd128(abcd_i); rnd128(wk_i); fsel_i = 2'(k);
      @(negedge clk);
      chk(abcd_o == hold && done_o == 1'b0, "R10 hold", abcd_o, hold);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule